// File: doc/BRIEF.md
# ModRM/SIB Addressing-Form Resolver

This block sits in a byte-serial instruction decoder just after the opcode stage. The opcode is already known. When the ModRM byte arrives, the block works out three things from it and from the effective address width: how many displacement bytes follow, whether a scale-index-base (SIB) byte comes next, and how many immediate bytes the instruction carries.

The immediate size normally comes in from the opcode tables. The block corrects it for the group-3 test form of the one-byte opcodes F6 and F7. That form carries an immediate even though its sibling forms do not.

The result is registered as a single decision about what the byte collector must fetch next: a SIB byte, displacement bytes, immediate bytes, or nothing. If a SIB byte is needed, the block waits for it. When it arrives, the block revises the displacement and the decision. Both addressing bytes are exported with the result so that later stages can use them unchanged.

Top module: `rsv_top`

## Requirements
- R1: With 16-bit addressing (`addr_mode` = 0), the displacement size is set as follows:
  - mod=2, or mod=0 with rm=6, gives 2 bytes.
  - mod=1 gives 1 byte.
  - Every other case gives 0 bytes.
- R2: With 32-bit or 64-bit addressing (`addr_mode` = 1, 2 or 3), the displacement size is set as follows:
  - mod=2, or mod=0 with rm=5, gives 4 bytes.
  - mod=1 gives 1 byte.
  - Every other case gives 0 bytes.
- R3: A SIB byte is awaited (`sib_wait`=1, `next_step`=1) only when all three hold: rm=4, mod is not 3, and the addressing is not 16-bit. The ModRM fields are mod=bits 7:6, reg=bits 5:3 and rm=bits 2:0.
- R4: When a SIB byte is accepted with mod=0 and SIB bits 2:0 equal to 5, the displacement size becomes 4. Otherwise the size set from ModRM is kept.
- R5: For the one-byte map (`op_map`=0) with opcode 0xF6 and ModRM bits 5:4 both zero, the immediate size is forced to 1. In every other case not covered by R6, `imm_bytes` equals `tab_imm`.
- R6: For the one-byte map with opcode 0xF7 and ModRM bits 5:4 both zero, the immediate size equals the operand size (1 << `op_lg`), except that an 8-byte operand size gives 4.
- R7: `next_step` is chosen in priority order: SIB (1), then displacement if nonzero (2), then immediate if nonzero (3), otherwise done (0).
- R8: `modrm_q` holds the last accepted ModRM byte. `sib_q` holds the accepted SIB byte, and is cleared to 0 when a new ModRM byte is accepted. Both hold their values between accepts.
- R9: `sib_valid` is accepted only while `sib_wait`=1. At any other time it changes no output.
- R10: After reset, every output is 0.
- R11: `res_valid` is high for exactly one cycle, in the cycle after each accepted ModRM or SIB byte.
- R12: If `modrm_valid` and `sib_valid` are both high, the ModRM byte wins. A ModRM byte that arrives while a SIB byte is awaited starts a new decision and abandons the pending SIB byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modrm_valid | input | 1 | ModRM byte and its context are valid this cycle |
| modrm_byte | input | 8 | ModRM byte |
| addr_mode | input | 2 | Address width: 0 = 16-bit, 1 = 32-bit, 2 and 3 = 64-bit |
| op_lg | input | 2 | log2 of the operand size in bytes |
| op_map | input | 2 | Opcode map: 0 = one-byte, 1 = two-byte, 2 and 3 = three-byte |
| opcode | input | 8 | Final opcode byte |
| tab_imm | input | IMM_W | Immediate size in bytes from the opcode tables |
| sib_valid | input | 1 | SIB byte valid this cycle |
| sib_byte | input | 8 | SIB byte |
| res_valid | output | 1 | One-cycle pulse: a new decision is on the outputs |
| disp_bytes | output | DISP_W | Displacement size in bytes |
| imm_bytes | output | IMM_W | Corrected immediate size in bytes |
| next_step | output | 2 | 0 done, 1 SIB, 2 displacement, 3 immediate |
| sib_wait | output | 1 | A SIB byte is awaited |
| modrm_q | output | 8 | Registered ModRM byte |
| sib_q | output | 8 | Registered SIB byte |

## Verification
The hardest state to reach is the second revision, where a SIB byte with base 5 and mod=0 turns a zero displacement into four bytes. It needs a 32-bit or 64-bit ModRM with rm=4, then a SIB byte on a later cycle. Directed sequences build this case, along with a ModRM that overrides a pending SIB and a SIB offered when none is awaited. A long random phase then mixes all four address modes, all opcode maps, F6/F7 test and non-test reg values, and independent valid strobes. During that phase a behavioural model is compared against the outputs on every cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int DISP_W = 3;

  typedef enum logic [1:0] {
    STEP_DONE = 2'd0,
    STEP_SIB  = 2'd1,
    STEP_DISP = 2'd2,
    STEP_IMM  = 2'd3
  } step_e;

  localparam logic [1:0] AM_16   = 2'd0;
  localparam logic [1:0] MAP_ONE = 2'd0;
  localparam logic [2:0] RM_SIB  = 3'd4;
  localparam logic [7:0] OPC_GRP3_B = 8'hF6;
  localparam logic [7:0] OPC_GRP3_V = 8'hF7;

  // displacement length implied by a ModRM byte
  function automatic logic [DISP_W-1:0] disp_len(input logic narrow,
                                                  input logic [1:0] md,
                                                  input logic [2:0] rm);
    logic [DISP_W-1:0] full;
    logic [2:0]        abs_rm;
    full   = narrow ? DISP_W'(2) : DISP_W'(4);
    abs_rm = narrow ? 3'd6 : 3'd5;
    if (md == 2'd1)                         return DISP_W'(1);
    if (md == 2'd2)                         return full;
    if (md == 2'd0 && rm == abs_rm)         return full;
    return '0;
  endfunction

  function automatic logic sib_follows(input logic narrow,
                                       input logic [1:0] md,
                                       input logic [2:0] rm);
    return !narrow && (md != 2'd3) && (rm == RM_SIB);
  endfunction
endpackage

// File: rtl/rsv_modrm_eval.sv
module rsv_modrm_eval
  import rsv_pkg::*;
#(
  parameter int DW = DISP_W
) (
  input  logic [1:0]    addr_mode,
  input  logic [7:0]    modrm,
  output logic [DW-1:0] disp,
  output logic          sib_need,
  output logic          narrow
);
  logic [1:0] md;
  logic [2:0] rm;

  assign md     = modrm[7:6];
  assign rm     = modrm[2:0];
  assign narrow = (addr_mode == AM_16);

  always_comb begin
    disp     = DW'(disp_len(narrow, md, rm));
    sib_need = sib_follows(narrow, md, rm);
  end
endmodule

// File: rtl/rsv_imm_adjust.sv
module rsv_imm_adjust
  import rsv_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic [1:0]    op_map,
  input  logic [7:0]    opcode,
  input  logic [7:0]    modrm,
  input  logic [1:0]    op_lg,
  input  logic [IW-1:0] tab_imm,
  output logic [IW-1:0] imm,
  output logic          forced
);
  logic          test_form;
  logic [IW-1:0] op_bytes;

  // reg field values 0 and 1 select the test form
  assign test_form = (op_map == MAP_ONE) && (modrm[5:4] == 2'b00);
  assign op_bytes  = (op_lg == 2'd3) ? IW'(4) : (IW'(1) << op_lg);

  always_comb begin
    imm    = tab_imm;
    forced = 1'b0;
    if (test_form && opcode == OPC_GRP3_B) begin
      imm    = IW'(1);
      forced = 1'b1;
    end else if (test_form && opcode == OPC_GRP3_V) begin
      imm    = op_bytes;
      forced = 1'b1;
    end
  end
endmodule

// File: rtl/rsv_step_pick.sv
module rsv_step_pick
  import rsv_pkg::*;
#(
  parameter int DW = DISP_W,
  parameter int IW = 4
) (
  input  logic          sib_need,
  input  logic [DW-1:0] disp,
  input  logic [IW-1:0] imm,
  output step_e         step
);
  always_comb begin
    if (sib_need)          step = STEP_SIB;
    else if (disp != '0)   step = STEP_DISP;
    else if (imm != '0)    step = STEP_IMM;
    else                   step = STEP_DONE;
  end
endmodule

// File: rtl/rsv_top.sv
module rsv_top
  import rsv_pkg::*;
#(
  parameter int IMM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modrm_valid,
  input  logic [7:0]        modrm_byte,
  input  logic [1:0]        addr_mode,
  input  logic [1:0]        op_lg,
  input  logic [1:0]        op_map,
  input  logic [7:0]        opcode,
  input  logic [IMM_W-1:0]  tab_imm,
  input  logic              sib_valid,
  input  logic [7:0]        sib_byte,
  output logic              res_valid,
  output logic [DISP_W-1:0] disp_bytes,
  output logic [IMM_W-1:0]  imm_bytes,
  output logic [1:0]        next_step,
  output logic              sib_wait,
  output logic [7:0]        modrm_q,
  output logic [7:0]        sib_q
);
  localparam int NPH = 2;  // phase 0: ModRM, phase 1: SIB

  // named events
  logic              take_modrm, take_sib;
  logic [DISP_W-1:0] m_disp, s_disp;
  logic              m_sib_need, m_narrow, m_forced;
  logic [IMM_W-1:0]  m_imm;
  logic              base_abs;

  logic [DISP_W-1:0] ph_disp [NPH];
  logic [IMM_W-1:0]  ph_imm  [NPH];
  logic              ph_sib  [NPH];
  step_e             ph_step [NPH];

  logic              rv_q, wait_q;
  logic [DISP_W-1:0] disp_q;
  logic [IMM_W-1:0]  imm_q;
  step_e             step_q;
  logic [7:0]        mrm_q, sb_q;

  assign take_modrm = modrm_valid;
  assign take_sib   = sib_valid && wait_q && !modrm_valid;

  rsv_modrm_eval #(.DW(DISP_W)) u_eval (
    .addr_mode (addr_mode),
    .modrm     (modrm_byte),
    .disp      (m_disp),
    .sib_need  (m_sib_need),
    .narrow    (m_narrow)
  );

  rsv_imm_adjust #(.IW(IMM_W)) u_imm (
    .op_map  (op_map),
    .opcode  (opcode),
    .modrm   (modrm_byte),
    .op_lg   (op_lg),
    .tab_imm (tab_imm),
    .imm     (m_imm),
    .forced  (m_forced)
  );

  // SIB base 5 with mod 0 means a 32-bit absolute displacement
  assign base_abs = (mrm_q[7:6] == 2'd0) && (sib_byte[2:0] == 3'd5);
  assign s_disp   = base_abs ? DISP_W'(4) : disp_q;

  assign ph_disp[0] = m_disp;
  assign ph_imm[0]  = m_imm;
  assign ph_sib[0]  = m_sib_need;
  assign ph_disp[1] = s_disp;
  assign ph_imm[1]  = imm_q;
  assign ph_sib[1]  = 1'b0;

  for (genvar p = 0; p < NPH; p++) begin : g_pick
    rsv_step_pick #(.DW(DISP_W), .IW(IMM_W)) u_pick (
      .sib_need (ph_sib[p]),
      .disp     (ph_disp[p]),
      .imm      (ph_imm[p]),
      .step     (ph_step[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      wait_q <= 1'b0;
      disp_q <= '0;
      imm_q  <= '0;
      step_q <= STEP_DONE;
      mrm_q  <= '0;
      sb_q   <= '0;
    end else begin
      rv_q <= 1'b0;
      if (take_modrm) begin
        rv_q   <= 1'b1;
        disp_q <= ph_disp[0];
        imm_q  <= ph_imm[0];
        step_q <= ph_step[0];
        wait_q <= ph_sib[0];
        mrm_q  <= modrm_byte;
        sb_q   <= '0;
      end else if (take_sib) begin
        rv_q   <= 1'b1;
        disp_q <= ph_disp[1];
        step_q <= ph_step[1];
        wait_q <= 1'b0;
        sb_q   <= sib_byte;
      end
    end
  end

  assign res_valid  = rv_q;
  assign disp_bytes = disp_q;
  assign imm_bytes  = imm_q;
  assign next_step  = step_q;
  assign sib_wait   = wait_q;
  assign modrm_q    = mrm_q;
  assign sib_q      = sb_q;

  // ---------------- assertions ----------------
  assert_narrow_no4_R1: assert property (@(posedge clk) disable iff (!rst_n)
    modrm_valid && addr_mode == AM_16 |=> disp_bytes != DISP_W'(4));

  assert_wide_no2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    modrm_valid && addr_mode != AM_16 |=> disp_bytes != DISP_W'(2));

  assert_no_sib16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    modrm_valid && addr_mode == AM_16 |=> !sib_wait);

  assert_base_abs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_sib && base_abs |=> disp_bytes == DISP_W'(4) && next_step == STEP_DISP);

  assert_f6_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    modrm_valid && m_forced && opcode == OPC_GRP3_B |=> imm_bytes == IMM_W'(1));

  assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && next_step == STEP_DONE |-> disp_bytes == '0 && imm_bytes == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !modrm_valid && !sib_valid |=> $stable(modrm_q) && $stable(sib_q));

  assert_wait_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sib_wait |-> next_step == STEP_SIB);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !modrm_valid && !(sib_valid && sib_wait) |=> !res_valid);
endmodule

// File: tb/test_rsv_top.sv
module test_rsv_top;
  localparam int IMM_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modrm_valid = 1'b0;
  logic [7:0] modrm_byte = '0;
  logic [1:0] addr_mode = '0;
  logic [1:0] op_lg = '0;
  logic [1:0] op_map = '0;
  logic [7:0] opcode = '0;
  logic [IMM_W-1:0] tab_imm = '0;
  logic sib_valid = 1'b0;
  logic [7:0] sib_byte = '0;
  logic res_valid;
  logic [2:0] disp_bytes;
  logic [IMM_W-1:0] imm_bytes;
  logic [1:0] next_step;
  logic sib_wait;
  logic [7:0] modrm_q, sib_q;

  always #2 clk = ~clk;  // 250 MHz

  rsv_top #(.IMM_W(IMM_W)) i_rsv_top (
    .clk, .rst_n, .modrm_valid, .modrm_byte, .addr_mode, .op_lg, .op_map,
    .opcode, .tab_imm, .sib_valid, .sib_byte, .res_valid, .disp_bytes,
    .imm_bytes, .next_step, .sib_wait, .modrm_q, .sib_q
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int e_rv = 0, e_disp = 0, e_imm = 0, e_step = 0, e_wait = 0, e_mrm = 0, e_sib = 0;
  string e_dtag = "R1", e_itag = "R5";

  function automatic int ref_disp(int am, int md, int rm);
    if (md == 1) return 1;
    if (am == 0) return (md == 2 || (md == 0 && rm == 6)) ? 2 : 0;
    return (md == 2 || (md == 0 && rm == 5)) ? 4 : 0;
  endfunction

  function automatic int ref_step(int sib, int d, int i);
    if (sib != 0) return 1;
    if (d != 0) return 2;
    if (i != 0) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_rv <= 0; e_disp <= 0; e_imm <= 0; e_step <= 0; e_wait <= 0; e_mrm <= 0; e_sib <= 0;
    end else if (modrm_valid) begin
      int md, rm, sib, d, im, tst;
      md  = modrm_byte / 64;
      rm  = modrm_byte % 8;
      sib = (addr_mode != 0 && md != 3 && rm == 4) ? 1 : 0;
      d   = ref_disp(addr_mode, md, rm);
      tst = (op_map == 0 && ((modrm_byte / 8) % 8) < 2) ? 1 : 0;
      im  = tab_imm;
      if (tst == 1 && opcode == 8'hF6) im = 1;
      if (tst == 1 && opcode == 8'hF7) im = (op_lg == 3) ? 4 : (1 << op_lg);
      e_rv <= 1; e_disp <= d; e_imm <= im; e_step <= ref_step(sib, d, im);
      e_wait <= sib; e_mrm <= modrm_byte; e_sib <= 0;
      e_dtag <= (addr_mode == 0) ? "R1" : "R2";
      e_itag <= (opcode == 8'hF7) ? "R6" : "R5";
    end else if (sib_valid && e_wait == 1) begin
      int d;
      d = (e_mrm / 64 == 0 && sib_byte % 8 == 5) ? 4 : e_disp;
      e_rv <= 1; e_disp <= d; e_step <= ref_step(0, d, e_imm);
      e_wait <= 0; e_sib <= sib_byte; e_dtag <= "R4";
    end else begin
      e_rv <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11", "res_valid", res_valid, e_rv);
      chk(e_dtag, "disp_bytes", disp_bytes, e_disp);
      chk(e_itag, "imm_bytes", imm_bytes, e_imm);
      chk("R7", "next_step", next_step, e_step);
      chk("R3", "sib_wait", sib_wait, e_wait);
      chk("R8", "modrm_q", modrm_q, e_mrm);
      chk("R8", "sib_q", sib_q, e_sib);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put_modrm(input int am, input int mb, input int lg, input int mp,
                           input int opc, input int ti);
    modrm_valid = 1'b1; modrm_byte = 8'(mb); addr_mode = 2'(am); op_lg = 2'(lg);
    op_map = 2'(mp); opcode = 8'(opc); tab_imm = IMM_W'(ti);
    @(negedge clk);
    modrm_valid = 1'b0;
  endtask

  task automatic put_sib(input int sb);
    sib_valid = 1'b1; sib_byte = 8'(sb);
    @(negedge clk);
    sib_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "res_valid", res_valid, 0);
    chk("R10", "disp_bytes", disp_bytes, 0);
    chk("R10", "next_step", next_step, 0);
    chk("R10", "sib_wait", sib_wait, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: 16-bit forms
    put_modrm(0, 8'h06, 1, 1, 8'h10, 0);
    chk("R1", "disp mod0 rm6", disp_bytes, 2); chk("R7", "step", next_step, 2);
    put_modrm(0, 8'h44, 1, 1, 8'h10, 0);
    chk("R1", "disp mod1", disp_bytes, 1); chk("R3", "no sib in 16-bit", sib_wait, 0);
    put_modrm(0, 8'hC4, 1, 1, 8'h10, 2);
    chk("R7", "imm step", next_step, 3); chk("R1", "disp mod3", disp_bytes, 0);
    // R11: pulse drops
    @(negedge clk);
    chk("R11", "pulse dropped", res_valid, 0);

    // R2: 32-bit absolute
    put_modrm(1, 8'h05, 2, 1, 8'h20, 0);
    chk("R2", "disp mod0 rm5", disp_bytes, 4);

    // R3/R8: 64-bit SIB then base 0
    put_modrm(2, 8'h84, 2, 1, 8'h20, 0);
    chk("R3", "sib awaited", sib_wait, 1); chk("R3", "step sib", next_step, 1);
    put_sib(8'h88);
    chk("R8", "sib_q", sib_q, 8'h88); chk("R7", "step disp", next_step, 2);
    chk("R2", "disp kept", disp_bytes, 4);

    // R4: base 5 forcing
    put_modrm(1, 8'h04, 2, 1, 8'h20, 0);
    put_sib(8'h25);
    chk("R4", "base5 disp", disp_bytes, 4); chk("R4", "base5 step", next_step, 2);
    put_modrm(1, 8'h04, 2, 1, 8'h20, 0);
    put_sib(8'h23);
    chk("R4", "base3 disp", disp_bytes, 0); chk("R7", "done", next_step, 0);

    // R9: sib ignored when none awaited
    put_sib(8'h55);
    chk("R9", "ignored rv", res_valid, 0); chk("R9", "ignored sib_q", sib_q, 8'h23);

    // R5/R6: test form
    put_modrm(1, 8'hC0, 2, 0, 8'hF6, 0);
    chk("R5", "F6 reg0", imm_bytes, 1); chk("R7", "imm step", next_step, 3);
    put_modrm(1, 8'hC8, 2, 0, 8'hF6, 0);
    chk("R5", "F6 reg1", imm_bytes, 1);
    put_modrm(1, 8'hD0, 2, 0, 8'hF6, 0);
    chk("R5", "F6 reg2", imm_bytes, 0);
    put_modrm(2, 8'hC0, 3, 0, 8'hF7, 0);
    chk("R6", "F7 op8", imm_bytes, 4);
    put_modrm(1, 8'hC0, 1, 0, 8'hF7, 0);
    chk("R6", "F7 op2", imm_bytes, 2);
    put_modrm(1, 8'hC0, 1, 1, 8'hF7, 0);
    chk("R6", "F7 other map", imm_bytes, 0);

    // R12: ModRM overrides pending SIB, and wins a same-cycle race
    put_modrm(1, 8'h04, 2, 1, 8'h20, 0);
    sib_valid = 1'b1; sib_byte = 8'h25;
    put_modrm(1, 8'hC0, 2, 1, 8'h20, 0);
    sib_valid = 1'b0;
    chk("R12", "sib dropped", sib_wait, 0); chk("R12", "sib_q cleared", sib_q, 0);
    chk("R12", "modrm taken", modrm_q, 8'hC0);

    // random phase checked by the model
    for (int k = 0; k < 4000; k++) begin
      int pick;
      modrm_valid = ($urandom_range(0, 2) == 0);
      modrm_byte  = 8'($urandom);
      addr_mode   = 2'($urandom);
      op_lg       = 2'($urandom);
      op_map      = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom);
      pick        = $urandom_range(0, 3);
      opcode      = (pick == 0) ? 8'hF6 : (pick == 1) ? 8'hF7 : 8'($urandom);
      pick        = $urandom_range(0, 4);
      tab_imm     = (pick == 4) ? IMM_W'(8) : IMM_W'((pick == 0) ? 0 : (1 << (pick - 1)));
      sib_valid   = ($urandom_range(0, 1) == 0);
      sib_byte    = 8'($urandom);
      @(negedge clk);
    end
    modrm_valid = 1'b0; sib_valid = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule